// File: doc/BRIEF.md
# IPI Command Dispatcher

This block turns 64-bit inter-processor send commands into 32-bit write transactions on a target register bus. A bus of this kind reaches the register space of each core. A 2-bit opcode presented with the command word picks one of three kinds of send. A plain interrupt send sets one bit in the target core's interrupt-set register. A mailbox send writes one of eight mailbox words of the target core. An arbitrary send writes any 16-bit address on the target core.

The two data sends carry a 4-bit byte-keep mask. When any bit of that mask is set, the dispatcher first issues a read to the same core and address. It waits for the returned word and merges the kept bytes of the old word with the payload bytes. Only then does it issue the write. One command is handled at a time. A single-cycle completion pulse follows the accepted final write.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After synchronous reset, `cmd_ready` is 1, and `tgt_req` and `done` are 0.
- R2: Opcode 0 (plain interrupt send) issues exactly one write with no read. The write goes to core `cmd_word[25:16]` at address 0x1008, with data `1 << cmd_word[4:0]`. Bits 30:27 have no effect on this opcode.
- R3: Opcode 1 (mailbox send) targets core `cmd_word[25:16]` at address 0x1020 + 4*`cmd_word[4:2]`. Bits 1:0 of the word do not change the address.
- R4: Opcode 2 (arbitrary send) targets core `cmd_word[25:16]` at address `cmd_word[15:0]`.
- R5: For opcodes 1 and 2 with `cmd_word[30:27]` all zero, no read is issued, and the write data is `cmd_word[63:32]` unchanged.
- R6: For opcodes 1 and 2 with `cmd_word[30:27]` nonzero, one read (`tgt_rd`=1) to the same core and address comes first. After it, one write comes whose byte i (bits 8i+7:8i) is the returned read byte when `cmd_word[27+i]` is 1, and the payload byte otherwise. The write request is not raised before `tgt_rvalid` returns.
- R7: While `tgt_req` is 1 and `tgt_ready` is 0, the request and its core, address, read flag and write data stay unchanged on the next cycle.
- R8: `done` is 1 for exactly one cycle. That cycle is the one right after the clock edge at which the final write was accepted (`tgt_req`, `!tgt_rd`, `tgt_ready`). It is 0 at all other times.
- R9: After a valid-opcode command is accepted, `cmd_ready` is 0 until the command completes.
- R10: Opcode 3 is accepted and dropped. It produces no target request and no `done`, and `cmd_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word and opcode are valid |
| cmd_ready | output | 1 | Dispatcher is idle and takes a command |
| cmd_op | input | 2 | 0 interrupt, 1 mailbox, 2 arbitrary, 3 dropped |
| cmd_word | input | 64 | Send command word |
| tgt_req | output | 1 | Target bus request |
| tgt_ready | input | 1 | Target accepts the request this cycle |
| tgt_rd | output | 1 | 1 for a read, 0 for a write |
| tgt_core | output | 10 | Target core identifier |
| tgt_addr | output | 16 | Target register address |
| tgt_wdata | output | 32 | Write data |
| tgt_rvalid | input | 1 | Read data return strobe |
| tgt_rdata | input | 32 | Returned read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the target raises `tgt_rvalid` only while a read is outstanding, for a single cycle per accepted read. They also assume that `cmd_word` and `cmd_op` are steady while `cmd_valid` waits for `cmd_ready`. The bench's target model asserts `tgt_ready` after a varying delay of zero to two cycles. It returns read data one or two cycles after each accepted read and never otherwise. The command driver holds its inputs until the handshake completes and starts the next command only after the previous one has finished.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;

  typedef enum logic [1:0] {
    OP_IPI  = 2'd0,
    OP_MAIL = 2'd1,
    OP_ANY  = 2'd2,
    OP_RSVD = 2'd3
  } ipi_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_RDATA,
    ST_WRITE,
    ST_DONE
  } disp_state_e;

  // command field positions (decoded by the target side's convention)
  localparam int CORE_LSB    = 16;
  localparam int KEEP_LSB    = 27;
  localparam int PAYLOAD_LSB = 32;

  localparam logic [15:0] IPI_SET_ADDR = 16'h1008;
  localparam logic [15:0] MBOX_BASE    = 16'h1020;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_disp_pkg::*;
#(
  parameter int CORE_W     = 10,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8
) (
  input  logic [1:0]                    op,
  input  logic [PAYLOAD_LSB+DATA_W-1:0] word,
  output logic                          op_ok,
  output logic [CORE_W-1:0]             core,
  output logic [ADDR_W-1:0]             addr,
  output logic [DATA_W-1:0]             payload,
  output logic [DATA_W/8-1:0]           keep,
  output logic                          need_rd
);

  localparam int NBYTES  = DATA_W / 8;
  localparam int SHIFT_W = $clog2(DATA_W);
  localparam int IDX_W   = $clog2(MBOX_WORDS);

  logic [ADDR_W-1:0] mbox_off;
  logic              unused_bits;

  assign unused_bits = ^{word[PAYLOAD_LSB-1], word[KEEP_LSB-1]};
  assign mbox_off    = ADDR_W'({word[IDX_W+1:2], 2'b00});
  assign core        = word[CORE_LSB +: CORE_W];

  always_comb begin
    op_ok   = 1'b1;
    addr    = '0;
    payload = word[PAYLOAD_LSB +: DATA_W];
    keep    = word[KEEP_LSB +: NBYTES];
    unique case (op)
      OP_IPI: begin
        addr    = ADDR_W'(IPI_SET_ADDR);
        payload = DATA_W'(1) << word[SHIFT_W-1:0];
        keep    = '0;
      end
      OP_MAIL: addr = ADDR_W'(MBOX_BASE) + mbox_off;
      OP_ANY:  addr = word[ADDR_W-1:0];
      default: begin
        op_ok = 1'b0;
        keep  = '0;
      end
    endcase
  end

  assign need_rd = |keep;

endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   old_word,
  input  logic [DATA_W-1:0]   new_word,
  input  logic [DATA_W/8-1:0] keep,
  output logic [DATA_W-1:0]   merged
);

  localparam int NBYTES = DATA_W / 8;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign merged[8*i +: 8] = keep[i] ? old_word[8*i +: 8] : new_word[8*i +: 8];
  end

endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
  import ipi_disp_pkg::*;
#(
  parameter int CORE_W     = 10,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [1:0]                    cmd_op,
  input  logic [PAYLOAD_LSB+DATA_W-1:0] cmd_word,
  output logic                          tgt_req,
  input  logic                          tgt_ready,
  output logic                          tgt_rd,
  output logic [CORE_W-1:0]             tgt_core,
  output logic [ADDR_W-1:0]             tgt_addr,
  output logic [DATA_W-1:0]             tgt_wdata,
  input  logic                          tgt_rvalid,
  input  logic [DATA_W-1:0]             tgt_rdata,
  output logic                          done
);

  localparam int NBYTES = DATA_W / 8;

  disp_state_e        state;
  logic               dec_ok;
  logic [CORE_W-1:0]  dec_core;
  logic [ADDR_W-1:0]  dec_addr;
  logic [DATA_W-1:0]  dec_payload;
  logic [NBYTES-1:0]  dec_keep;
  logic               dec_need_rd;
  logic [CORE_W-1:0]  core_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [NBYTES-1:0]  keep_q;
  logic [DATA_W-1:0]  merged;

  ipi_cmd_decode #(
    .CORE_W(CORE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)
  ) u_decode (
    .op(cmd_op), .word(cmd_word), .op_ok(dec_ok), .core(dec_core),
    .addr(dec_addr), .payload(dec_payload), .keep(dec_keep), .need_rd(dec_need_rd)
  );

  ipi_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word(tgt_rdata), .new_word(data_q), .keep(keep_q), .merged(merged)
  );

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:       if (cmd_valid && dec_ok) state <= dec_need_rd ? ST_READ : ST_WRITE;
        ST_READ:       if (tgt_ready) state <= ST_WAIT_RDATA;
        ST_WAIT_RDATA: if (tgt_rvalid) state <= ST_WRITE;
        ST_WRITE:      if (tgt_ready) state <= ST_DONE;
        default:       state <= ST_IDLE;
      endcase
    end
  end

  // command datapath
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && cmd_valid && dec_ok) begin
      core_q <= dec_core;
      addr_q <= dec_addr;
      data_q <= dec_payload;
      keep_q <= dec_keep;
    end else if (state == ST_WAIT_RDATA && tgt_rvalid) begin
      data_q <= merged;
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign tgt_req   = (state == ST_READ) || (state == ST_WRITE);
  assign tgt_rd    = (state == ST_READ);
  assign tgt_core  = core_q;
  assign tgt_addr  = addr_q;
  assign tgt_wdata = data_q;
  assign done      = (state == ST_DONE);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && !tgt_ready) |=> (tgt_req && $stable(tgt_rd) && $stable(tgt_core)
                                 && $stable(tgt_addr) && $stable(tgt_wdata)))
    else $error("request changed while stalled");

  // R8
  done_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && !tgt_rd && tgt_ready) |=> done)
    else $error("done missing after accepted write");

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done longer than one cycle");

  // R6
  rd_waits_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && tgt_rd && tgt_ready) |=> !tgt_req)
    else $error("request raised before read data returned");

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op != OP_RSVD) |=> !cmd_ready)
    else $error("ready stayed high after accepting a command");

  // R10
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == OP_RSVD) |=> (cmd_ready && !tgt_req))
    else $error("reserved opcode started a transaction");

endmodule

// File: tb/ipi_cmd_dispatch_tb_top.sv
module ipi_cmd_dispatch_tb_top;

  typedef struct {
    bit          rd;
    logic [9:0]  core;
    logic [15:0] addr;
    logic [31:0] wdata;
    string       tag;
  } txn_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [63:0] cmd_word = '0;
  logic        tgt_req;
  logic        tgt_ready = 1'b0;
  logic        tgt_rd;
  logic [9:0]  tgt_core;
  logic [15:0] tgt_addr;
  logic [31:0] tgt_wdata;
  logic        tgt_rvalid = 1'b0;
  logic [31:0] tgt_rdata = '0;
  logic        done;

  int   checks = 0;
  int   failures = 0;
  int   done_cnt = 0;
  txn_t exp_q[$];

  always #2 clk = ~clk;

  ipi_cmd_dispatch dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_word(cmd_word), .tgt_req(tgt_req), .tgt_ready(tgt_ready),
    .tgt_rd(tgt_rd), .tgt_core(tgt_core), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_rvalid(tgt_rvalid), .tgt_rdata(tgt_rdata), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] old_val(input logic [9:0] c, input logic [15:0] a);
    return {a, 6'd0, c} ^ 32'hA55A_C33C;
  endfunction

  function automatic logic [63:0] mk(input logic [31:0] pay, input logic [3:0] keep,
                                     input logic [9:0] core, input logic [15:0] low);
    return {pay, 1'b0, keep, 1'b0, core, low};
  endfunction

  // target model and scoreboard monitor
  int          wait_cnt = 0;
  int          rv_cnt = -1;
  int          pat = 0;
  bit          exp_done = 0;
  bit          hold_v = 0;
  txn_t        hold_t;
  logic [31:0] rd_val = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (exp_done) begin
        chk(done == 1'b1, "R8", "done after write", done, 1);
        if (done) done_cnt++;
        exp_done = 0;
      end else if (done) begin
        chk(1'b0, "R8", "unexpected done", done, 0);
      end

      if (hold_v) begin
        chk(tgt_req && tgt_rd == hold_t.rd && tgt_core == hold_t.core &&
            tgt_addr == hold_t.addr && tgt_wdata == hold_t.wdata,
            "R7", "stalled request changed", {tgt_addr, tgt_wdata}, {hold_t.addr, hold_t.wdata});
        hold_v = 0;
      end

      tgt_rvalid = 1'b0;
      if (rv_cnt > 0) rv_cnt--;
      else if (rv_cnt == 0) begin
        tgt_rvalid = 1'b1;
        tgt_rdata  = rd_val;
        rv_cnt     = -1;
      end

      tgt_ready = 1'b0;
      if (tgt_req) begin
        if (wait_cnt > 0) begin
          wait_cnt--;
          hold_v = 1;
          hold_t.rd = tgt_rd; hold_t.core = tgt_core;
          hold_t.addr = tgt_addr; hold_t.wdata = tgt_wdata;
        end else begin
          tgt_ready = 1'b1;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected transaction", {tgt_rd, tgt_addr}, 0);
          end else begin
            txn_t e;
            e = exp_q.pop_front();
            chk(tgt_rd == e.rd, e.tag, "read flag", tgt_rd, e.rd);
            chk(tgt_core == e.core, e.tag, "core", tgt_core, e.core);
            chk(tgt_addr == e.addr, e.tag, "address", tgt_addr, e.addr);
            if (!e.rd) chk(tgt_wdata == e.wdata, e.tag, "write data", tgt_wdata, e.wdata);
          end
          if (tgt_rd) begin
            rd_val = old_val(tgt_core, tgt_addr);
            rv_cnt = pat % 2;
          end else begin
            exp_done = 1;
          end
          pat++;
          wait_cnt = pat % 3;
        end
      end
    end
  end

  // driver: pushes expected target transactions, then presents the command
  task automatic send(input logic [1:0] op, input logic [63:0] w, input string tag);
    txn_t        t;
    logic [3:0]  keep;
    logic [31:0] m;
    int          prev;
    keep   = w[30:27];
    t.core = w[25:16];
    t.tag  = tag;
    if (op == 2'd0) begin
      t.rd = 0; t.addr = 16'h1008; t.wdata = 32'd1 << w[4:0];
      exp_q.push_back(t);
    end else if (op != 2'd3) begin
      t.addr = (op == 2'd1) ? 16'h1020 + {11'd0, w[4:2], 2'b00} : w[15:0];
      if (keep != 0) begin
        t.rd = 1; t.wdata = '0;
        exp_q.push_back(t);
      end
      m = w[63:32];
      for (int i = 0; i < 4; i++)
        if (keep[i]) m[8*i +: 8] = old_val(t.core, t.addr) >> (8*i);
      t.rd = 0; t.wdata = m;
      exp_q.push_back(t);
    end
    prev      = done_cnt;
    cmd_op    = op;
    cmd_word  = w;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op != 2'd3) begin
      chk(cmd_ready == 1'b0, "R9", "ready while busy", cmd_ready, 0);
      while (done_cnt == prev) @(negedge clk);
      @(negedge clk);
    end else begin
      for (int k = 0; k < 3; k++) begin
        chk(cmd_ready && !tgt_req && !done, "R10", "dropped opcode activity",
            {cmd_ready, tgt_req, done}, 3'b100);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
    chk(tgt_req == 1'b0, "R1", "tgt_req after reset", tgt_req, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);

    send(2'd0, mk(32'hDEAD_BEEF, 4'hF, 10'h2A5, 16'h0005), "R2");
    send(2'd0, mk(32'h0, 4'h0, 10'h3FF, 16'hFFFF), "R2");
    send(2'd1, mk(32'h1234_5678, 4'h0, 10'h011, 16'h001F), "R3");
    send(2'd1, mk(32'hCAFE_F00D, 4'h0, 10'h100, 16'h0008), "R5");
    send(2'd1, mk(32'h8877_6655, 4'h5, 10'h0C3, 16'h0004), "R6");
    send(2'd2, mk(32'h0BAD_CAFE, 4'h0, 10'h155, 16'hBEEC), "R4");
    send(2'd3, mk(32'hFFFF_FFFF, 4'hF, 10'h001, 16'h1008), "R10");
    send(2'd2, mk(32'h1111_2222, 4'hF, 10'h3FF, 16'h0040), "R6");
    send(2'd2, mk(32'hAABB_CCDD, 4'h8, 10'h200, 16'h7FFC), "R6");
    send(2'd1, mk(32'h5566_7788, 4'h3, 10'h000, 16'h0010), "R6");
    send(2'd0, mk(32'h0, 4'h0, 10'h07E, 16'h0000), "R2");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R8 watchdog expired actual=hung expected=complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule